// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block takes configuration words from a three-wire serial link (a bit clock, a data line and an active-low frame enable) and keeps them in two registers. The register outputs drive the control fields of a synthesizer and transmit front end. A frame opens when the enable line falls. Data bits are captured on each rising bit-clock edge, most significant bit first. When the enable line rises, the frame closes and the last bit captured picks the target register. The link lines are asynchronous to the block. They pass through synchronizers and are sampled by a faster system clock.

A 24-bit shift register collects each frame and is cleared when a frame opens. Surplus leading bits fall off the top of the shift register. The block does not count clock pulses. The block also has a power-up input and a hold-enable input. While power is down, the hold-enable input decides whether the registers are kept or returned to their defaults.

The controller uses four states. `ST_IDLE` waits with the enable line high. `ST_SHIFT` collects bits while the enable line is low. `ST_LOAD` lasts one cycle and commits the word. `ST_OFF` is entered while power is down. The transitions are:
- idle-to-shift when the enable line goes low;
- shift-to-load when the enable line returns high;
- load-to-idle unconditionally;
- idle, shift or load to off when power drops;
- off-to-idle when power returns.

Top module: `cfg3w_port`

## Requirements
- R1: While the synchronized enable is low, each rising bit-clock edge shifts the data line into the LSB of the shift register, so the first bit sent ends up highest. Opening a frame clears the shift register.
- R2: When the enable rises, the last bit received (shift register bit 0) selects the target. A 1 loads word one from shift bits 23..1, and a 0 loads word two from shift bits 8..1. The other register is left unchanged.
- R3: The block does not count bit-clock pulses. Leading bits beyond the word length are discarded. Missing leading bits read as 0, so a frame with no clocks loads 0 into word two.
- R4: While power-up is low and hold-enable is high, both registers keep their contents.
- R5: While power-up is low and hold-enable is low, both registers return to the defaults of R6 and still hold them after power returns.
- R6: After reset, word one is 0x000E00 (bits 11, 10 and 9 set) and word two is 0xC0 (bits 7 and 6 set).
- R7: Word one bit fields are:
  - 22:21 reference code
  - 20:16 swallow count
  - 15:14 main code
  - 13 shaper polarity
  - 12 compensation polarity
  - 11 pump polarity
  - 10 shaper enable
  - 9 compensation enable
  - 8:6 shaper scale
  - 5:3 pretune code
  - 2:0 pump scale
- R8: Word two bit fields are:
  - 7 doubler enable
  - 6 amplifier enable
  - 5:3 compensation scale
  - 2:0 test select
- R9: Frames sent while power-up is low change neither register.
- R10: Outputs change only on a load or a power-down wipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Serial bit clock |
| bus_data | input | 1 | Serial data |
| bus_en_n | input | 1 | Active-low frame enable |
| pwr_up | input | 1 | Power-up, high = active |
| hold_en | input | 1 | Keep registers during power-down |
| ref_sel | output | 2 | Reference divider code |
| swallow_cnt | output | 5 | Swallow count |
| main_sel | output | 2 | Main divider code |
| shaper_pol | output | 1 | Pulse shaper output polarity |
| compens_pol | output | 1 | Compensation data polarity |
| pump_pol | output | 1 | Charge pump polarity |
| shaper_en | output | 1 | Pulse shaper enable |
| compens_en | output | 1 | Compensation enable |
| shaper_scale | output | 3 | Pulse shaper current scale |
| pretune_code | output | 3 | Oscillator pretune code |
| pump_scale | output | 3 | Charge pump current scale |
| doubler_en | output | 1 | Frequency doubler enable |
| amp_en | output | 1 | Loop amplifier enable |
| compens_scale | output | 3 | Compensation current scale |
| test_sel | output | 3 | Test mode select |

## Verification
The bench builds the block with the defaults: 23-bit and 8-bit words and two synchronizer stages. The link runs ten system clocks per bit. These values let one table drive full-length frames, over-long frames and short frames for both address values. The same build covers the no-clock frame, both power-down variants and frames sent while power is down.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    parameter int W1_BITS = 23;
    parameter int W2_BITS = 8;
    localparam int SR_BITS = W1_BITS + 1;

    localparam logic [W1_BITS-1:0] W1_DEFAULT = 23'h000E00;
    localparam logic [W2_BITS-1:0] W2_DEFAULT = 8'hC0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2,
        ST_OFF   = 2'd3
    } bus_state_t;

    typedef struct packed {
        logic [1:0] ref_sel;
        logic [4:0] swallow_cnt;
        logic [1:0] main_sel;
        logic       shaper_pol;
        logic       compens_pol;
        logic       pump_pol;
        logic       shaper_en;
        logic       compens_en;
        logic [2:0] shaper_scale;
        logic [2:0] pretune_code;
        logic [2:0] pump_scale;
    } word1_t;

    typedef struct packed {
        logic       doubler_en;
        logic       amp_en;
        logic [2:0] compens_scale;
        logic [2:0] test_sel;
    } word2_t;

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int             WIDTH   = 1,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/cfg3w_fsm.sv
module cfg3w_fsm
    import cfg3w_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_n_s,
    input  logic       pwr_s,
    input  logic       clk_rise,
    output bus_state_t state,
    output logic       sr_clr,
    output logic       sr_shift,
    output logic       commit
);

    bus_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!pwr_s)       state_nx = ST_OFF;
                else if (!en_n_s) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!pwr_s)      state_nx = ST_OFF;
                else if (en_n_s) state_nx = ST_LOAD;
            end
            ST_LOAD: begin
                if (!pwr_s) state_nx = ST_OFF;
                else        state_nx = ST_IDLE;
            end
            ST_OFF: begin
                if (pwr_s) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sr_clr   = 1'b0;
        sr_shift = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE:  sr_clr   = pwr_s && !en_n_s;
            ST_SHIFT: sr_shift = pwr_s && !en_n_s && clk_rise;
            ST_LOAD:  commit   = pwr_s;
            ST_OFF:   ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift #(
    parameter int BITS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift,
    input  logic            din,
    output logic [BITS-1:0] sr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr <= '0;
        else if (clr)   sr <= '0;
        else if (shift) sr <= {sr[BITS-2:0], din};
    end

endmodule

// File: rtl/cfg3w_regs.sv
module cfg3w_regs
    import cfg3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               wipe,
    input  logic [SR_BITS-1:0] sr,
    output logic [W1_BITS-1:0] w1,
    output logic [W2_BITS-1:0] w2,
    output logic               ld1,
    output logic               ld2
);

    logic addr_bit;

    assign addr_bit = sr[0];
    assign ld1      = commit &&  addr_bit;
    assign ld2      = commit && !addr_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w1 <= W1_DEFAULT;
        else if (wipe) w1 <= W1_DEFAULT;
        else if (ld1)  w1 <= sr[SR_BITS-1:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w2 <= W2_DEFAULT;
        else if (wipe) w2 <= W2_DEFAULT;
        else if (ld2)  w2 <= sr[W2_BITS:1];
    end

endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_clk,
    input  logic       bus_data,
    input  logic       bus_en_n,
    input  logic       pwr_up,
    input  logic       hold_en,
    output logic [1:0] ref_sel,
    output logic [4:0] swallow_cnt,
    output logic [1:0] main_sel,
    output logic       shaper_pol,
    output logic       compens_pol,
    output logic       pump_pol,
    output logic       shaper_en,
    output logic       compens_en,
    output logic [2:0] shaper_scale,
    output logic [2:0] pretune_code,
    output logic [2:0] pump_scale,
    output logic       doubler_en,
    output logic       amp_en,
    output logic [2:0] compens_scale,
    output logic [2:0] test_sel
);

    localparam int NSYNC = 5;
    // order: pwr, hold, en_n, data, clk
    localparam logic [NSYNC-1:0] SYNC_RST = 5'b10100;

    logic [NSYNC-1:0] sync_v;
    logic             pwr_s, hold_s, en_n_s, data_s, bclk_s, bclk_q;
    logic             clk_rise;
    bus_state_t       state;
    logic             sr_clr, sr_shift, commit, wipe, ld1, ld2;
    logic [SR_BITS-1:0] sr;
    logic [W1_BITS-1:0] w1;
    logic [W2_BITS-1:0] w2;
    word1_t           f1;
    word2_t           f2;

    cfg3w_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({pwr_up, hold_en, bus_en_n, bus_data, bus_clk}),
        .sync_out(sync_v)
    );

    assign {pwr_s, hold_s, en_n_s, data_s, bclk_s} = sync_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk_s;
    end

    assign clk_rise = bclk_s && !bclk_q;

    cfg3w_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_n_s  (en_n_s),
        .pwr_s   (pwr_s),
        .clk_rise(clk_rise),
        .state   (state),
        .sr_clr  (sr_clr),
        .sr_shift(sr_shift),
        .commit  (commit)
    );

    cfg3w_shift #(.BITS(SR_BITS)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sr_clr),
        .shift(sr_shift),
        .din  (data_s),
        .sr   (sr)
    );

    assign wipe = (state == ST_OFF) && !hold_s;

    cfg3w_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(commit),
        .wipe  (wipe),
        .sr    (sr),
        .w1    (w1),
        .w2    (w2),
        .ld1   (ld1),
        .ld2   (ld2)
    );

    assign f1 = word1_t'(w1);
    assign f2 = word2_t'(w2);

    assign ref_sel       = f1.ref_sel;
    assign swallow_cnt   = f1.swallow_cnt;
    assign main_sel      = f1.main_sel;
    assign shaper_pol    = f1.shaper_pol;
    assign compens_pol   = f1.compens_pol;
    assign pump_pol      = f1.pump_pol;
    assign shaper_en     = f1.shaper_en;
    assign compens_en    = f1.compens_en;
    assign shaper_scale  = f1.shaper_scale;
    assign pretune_code  = f1.pretune_code;
    assign pump_scale    = f1.pump_scale;
    assign doubler_en    = f2.doubler_en;
    assign amp_en        = f2.amp_en;
    assign compens_scale = f2.compens_scale;
    assign test_sel      = f2.test_sel;

endmodule

// File: rtl/cfg3w_checks.sv
module cfg3w_checks
    import cfg3w_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input bus_state_t         state,
    input logic               hold_s,
    input logic               ld1,
    input logic               ld2,
    input logic [W1_BITS-1:0] w1,
    input logic [W2_BITS-1:0] w2
);

    assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld1, ld2}));

    assert_load_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> ($past(state) == ST_SHIFT));

    assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && hold_s) |=> ($stable(w1) && $stable(w2)));

    assert_wipe_defaults_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !hold_s) |=> (w1 == W1_DEFAULT && w2 == W2_DEFAULT));

    assert_off_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!ld1 && !ld2));

    assert_quiet_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld1 && !ld2 && !(state == ST_OFF && !hold_s)) |=> ($stable(w1) && $stable(w2)));

endmodule

bind cfg3w_port cfg3w_checks u_checks (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .hold_s(hold_s),
    .ld1   (ld1),
    .ld2   (ld2),
    .w1    (w1),
    .w2    (w2)
);

// File: tb/cfg3w_port_test.sv
module cfg3w_port_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_clk = 1'b0;
    logic bus_data = 1'b0;
    logic bus_en_n = 1'b1;
    logic pwr_up = 1'b1;
    logic hold_en = 1'b0;

    logic [1:0] ref_sel;
    logic [4:0] swallow_cnt;
    logic [1:0] main_sel;
    logic       shaper_pol, compens_pol, pump_pol, shaper_en, compens_en;
    logic [2:0] shaper_scale, pretune_code, pump_scale;
    logic       doubler_en, amp_en;
    logic [2:0] compens_scale, test_sel;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cfg3w_port uut (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
        .bus_en_n(bus_en_n), .pwr_up(pwr_up), .hold_en(hold_en),
        .ref_sel(ref_sel), .swallow_cnt(swallow_cnt), .main_sel(main_sel),
        .shaper_pol(shaper_pol), .compens_pol(compens_pol), .pump_pol(pump_pol),
        .shaper_en(shaper_en), .compens_en(compens_en), .shaper_scale(shaper_scale),
        .pretune_code(pretune_code), .pump_scale(pump_scale),
        .doubler_en(doubler_en), .amp_en(amp_en), .compens_scale(compens_scale),
        .test_sel(test_sel)
    );

    // Field order per R7 and R8
    wire [22:0] obs1 = {ref_sel, swallow_cnt, main_sel, shaper_pol, compens_pol,
                        pump_pol, shaper_en, compens_en, shaper_scale,
                        pretune_code, pump_scale};
    wire [7:0]  obs2 = {doubler_en, amp_en, compens_scale, test_sel};

    localparam int NV = 7;
    localparam int          VN [NV] = '{24, 9, 30, 13, 10, 24, 9};
    localparam logic [31:0] VD [NV] = '{32'h0055678B, 32'h000000BC, 32'h2D03E1E1,
                                        32'h00001E66, 32'h0000034B, 32'h00FFFFFF,
                                        32'h00000000};
    localparam logic [22:0] VE1[NV] = '{23'h2AB3C5, 23'h2AB3C5, 23'h01F0F0,
                                        23'h01F0F0, 23'h0001A5, 23'h7FFFFF,
                                        23'h7FFFFF};
    localparam logic [7:0]  VE2[NV] = '{8'hC0, 8'h5E, 8'h5E, 8'h33, 8'h33, 8'h33,
                                        8'h00};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int nbits, input logic [31:0] data);
        bus_en_n = 1'b0;
        ticks(5);
        for (int i = nbits - 1; i >= 0; i--) begin
            bus_data = data[i];
            ticks(5);
            bus_clk = 1'b1;
            ticks(5);
            bus_clk = 1'b0;
        end
        ticks(5);
        bus_en_n = 1'b1;
        ticks(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(5);
        check("R6 word one reset", {9'd0, obs1}, 32'h000E00);
        check("R6 word two reset", {24'd0, obs2}, 32'hC0);

        // R1 R2 R3 R7 R8: table of frames
        for (int v = 0; v < NV; v++) begin
            send(VN[v], VD[v]);
            check($sformatf("R1/R2/R7 vec%0d word one", v), {9'd0, obs1}, {9'd0, VE1[v]});
            check($sformatf("R2/R8 vec%0d word two", v), {24'd0, obs2}, {24'd0, VE2[v]});
        end

        // R7 individual field positions after a known word
        send(24, {23'h2AB3C5, 1'b1});
        check("R7 ref_sel", {30'd0, ref_sel}, 32'd1);
        check("R7 swallow_cnt", {27'd0, swallow_cnt}, 32'h0A);
        check("R7 pretune_code", {29'd0, pretune_code}, 32'd0);
        check("R7 pump_scale", {29'd0, pump_scale}, 32'd5);
        send(9, {8'b10_011_110, 1'b0});
        check("R8 doubler_en", {31'd0, doubler_en}, 32'd1);
        check("R8 compens_scale", {29'd0, compens_scale}, 32'd3);
        check("R8 test_sel", {29'd0, test_sel}, 32'd6);

        // R3 frame without clocks loads zero into word two
        bus_en_n = 1'b0;
        ticks(20);
        bus_en_n = 1'b1;
        ticks(10);
        check("R3 empty frame word two", {24'd0, obs2}, 32'h00);
        check("R3 empty frame word one kept", {9'd0, obs1}, 32'h2AB3C5);

        // R4 and R9: power down with hold, frame ignored
        send(9, {8'h81, 1'b0});
        hold_en = 1'b1;
        pwr_up = 1'b0;
        ticks(10);
        send(24, {23'h123456, 1'b1});
        send(9, {8'h3C, 1'b0});
        check("R9 frame while off word one", {9'd0, obs1}, 32'h2AB3C5);
        check("R9 frame while off word two", {24'd0, obs2}, 32'h81);
        pwr_up = 1'b1;
        ticks(10);
        check("R4 hold word one", {9'd0, obs1}, 32'h2AB3C5);
        check("R4 hold word two", {24'd0, obs2}, 32'h81);

        // R5: power down without hold
        hold_en = 1'b0;
        pwr_up = 1'b0;
        ticks(10);
        check("R5 wiped while off", {24'd0, obs2}, 32'hC0);
        pwr_up = 1'b1;
        ticks(10);
        check("R5 word one default", {9'd0, obs1}, 32'h000E00);
        check("R5 word two default", {24'd0, obs2}, 32'hC0);

        // R10: idle bus clock toggles with enable high change nothing
        for (int k = 0; k < 4; k++) begin
            bus_data = k[0];
            bus_clk = 1'b1;
            ticks(5);
            bus_clk = 1'b0;
            ticks(5);
        end
        check("R10 idle toggles word one", {9'd0, obs1}, 32'h000E00);
        check("R10 idle toggles word two", {24'd0, obs2}, 32'hC0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule